// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block is a bus-attached peripheral with two independent 8-bit parallel ports, A and B. Every pin of either port can be an input or an output on its own. Each port also has two handshake lines. The first handshake line is always an input. The second can be an input or an output. Transitions on the handshake lines raise sticky status flags, and those flags can drive an active-low interrupt request, one request per port.

Each port holds three registers: a direction register, an output latch and a control register. Only two bus addresses serve each port, so six registers sit behind four addresses. Bit 2 of a port's control register chooses whether that port's shared address reaches the direction register or the data register.

Software follows a fixed start-up order. It clears bit 2, writes the direction register, sets bit 2, and from then on accesses data. The CPU side is synchronous. A write strobe and a read strobe are sampled on the clock. Three chip-select inputs gate every access.

Top module: `dual_port_adapter`

## Requirements
- R1: An access takes effect only when cs_hi_a=1, cs_hi_b=1 and cs_lo_n=0. With any other select pattern, writes change no register and bus_rdata keeps its value.
- R2: reg_sel selects the target register. 2'b00 selects port A's shared address and 2'b01 selects control A. 2'b10 selects port B's shared address and 2'b11 selects control B.
- R3: While control bit 2 of a port is 0, that port's shared address reads and writes the direction register. While the bit is 1, the shared address reads and writes the data register (the output latch). A write to one of these two registers leaves the other unchanged.
- R4: Direction bit i set to 1 enables pin i of that port as an output, and bit i set to 0 makes it an input. For example, 0x4C enables pins 6, 3 and 2. The pin_out bus always carries the output latch.
- R5: A read of the data register returns the latch bit for each output pin and the synchronized pin level for each input pin. bus_rdata is registered: it is valid on the cycle after the read strobe is sampled.
- R6: Reset clears the direction register, the output latch, the control register and both flags of each port. After reset all oe outputs are 0, both irq_n outputs are 1 and bus_rdata is 0.
- R7: Control bit 7 is a flag that is set by an active edge on handshake line 1. Control bit 1 chooses the active edge: 0 selects high-to-low and 1 selects low-to-high. The opposite edge does nothing.
- R8: Control bit 5 sets the mode of handshake line 2.
  - When bit 5 is 0, line 2 is an input. Control bit 6 is a flag that is set by its active edge. Bit 4 selects the edge (0 falling, 1 rising), and bit 3 must be 1 for that flag to be set.
  - When bit 5 is 1, line 2 is driven with oe=1 at the level held in bit 3, and bit 6 is never set.
- R9: Flag bits 7 and 6 are read-only. A control write loads only bits 5..0.
- R10: Reading a port's data register (bit 2 = 1) clears both flags of that port. Reading the direction register or the control register clears neither flag. An active edge detected in the same cycle as a clearing read keeps its flag set.
- R11: irq_n of a port is 0 exactly when control bit 0 is 1 and at least one of that port's flags is set. It follows the flags with no added cycle.
- R12: The two ports are independent: configuration, pins, flags and interrupt of one never affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_hi_a | input | 1 | Chip select, active high |
| cs_hi_b | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| reg_sel | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| a_pin_in | input | 8 | Port A pin levels |
| a_pin_out | output | 8 | Port A output latch |
| a_pin_oe | output | 8 | Port A output enables |
| a_hs1 | input | 1 | Port A handshake line 1 |
| a_hs2_in | input | 1 | Port A handshake line 2, input level |
| a_hs2_out | output | 1 | Port A handshake line 2, driven level |
| a_hs2_oe | output | 1 | Port A handshake line 2, output enable |
| a_irq_n | output | 1 | Port A interrupt request, active low |
| b_pin_in | input | 8 | Port B pin levels |
| b_pin_out | output | 8 | Port B output latch |
| b_pin_oe | output | 8 | Port B output enables |
| b_hs1 | input | 1 | Port B handshake line 1 |
| b_hs2_in | input | 1 | Port B handshake line 2, input level |
| b_hs2_out | output | 1 | Port B handshake line 2, driven level |
| b_hs2_oe | output | 1 | Port B handshake line 2, output enable |
| b_irq_n | output | 1 | Port B interrupt request, active low |

## Verification
- **Register writes:** A register write shows on pin_out, pin_oe and the handshake-2 outputs one clock edge after the strobe is sampled. A read result shows on bus_rdata at that same edge.
- **Pin inputs:** With two synchronizer stages, a pin change is readable from the third edge after it occurs.
- **Handshake flags:** A handshake edge sets its flag, and drops irq_n, at the third edge after the change. This edge counts the two synchronizer stages and the edge-history register.
- **Bench timing:** The bench drives inputs on falling edges and holds each directed check until the last of these edges has passed. It steps a behavioural model at every rising edge and compares it one time unit later. The model delays the pins through a history array, and one check places a clearing read on exactly the cycle a new edge is detected.

// File: rtl/pxa_pkg.sv
package pxa_pkg;

    localparam int BUS_W = 8;

    // control register field positions
    localparam int CTL_IRQ_EN  = 0;
    localparam int CTL_H1_RISE = 1;
    localparam int CTL_DATA    = 2;
    localparam int CTL_H2_LVL  = 3;
    localparam int CTL_H2_RISE = 4;
    localparam int CTL_H2_OUT  = 5;
    localparam int CFG_W       = 6;

    typedef enum logic [1:0] {
        SEL_A_SHARED = 2'b00,
        SEL_A_CTL    = 2'b01,
        SEL_B_SHARED = 2'b10,
        SEL_B_CTL    = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic [BUS_W-1:0] dir;
        logic [BUS_W-1:0] lat;
        logic [CFG_W-1:0] cfg;
        logic             flag1;
        logic             flag2;
        logic             h1_prev;
        logic             h2_prev;
    } port_state_t;

endpackage

// File: rtl/pxa_sync.sv
module pxa_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pxa_port.sv
module pxa_port
    import pxa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_shared,
    input  logic             wr_ctl,
    input  logic             rd_shared,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] pin_in,
    input  logic             hs1_in,
    input  logic             hs2_in,
    output logic [BUS_W-1:0] pin_out,
    output logic [BUS_W-1:0] pin_oe,
    output logic             hs2_out,
    output logic             hs2_oe,
    output logic             irq_n,
    output logic [BUS_W-1:0] shared_rdata,
    output logic [BUS_W-1:0] ctl_rdata
);
    port_state_t      st_d, st_q;
    logic [BUS_W-1:0] pin_s;
    logic             h1_s, h2_s;
    logic             h1_hit, h2_hit, rd_clear;

    pxa_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_s)
    );

    pxa_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_hs_sync (
        .clk(clk), .rst_n(rst_n), .din({hs2_in, hs1_in}), .dout({h2_s, h1_s})
    );

    always_comb begin
        st_d     = st_q;
        h1_hit   = st_q.cfg[CTL_H1_RISE] ? (h1_s & ~st_q.h1_prev)
                                         : (~h1_s & st_q.h1_prev);
        h2_hit   = ~st_q.cfg[CTL_H2_OUT] & st_q.cfg[CTL_H2_LVL] &
                   (st_q.cfg[CTL_H2_RISE] ? (h2_s & ~st_q.h2_prev)
                                          : (~h2_s & st_q.h2_prev));
        rd_clear = rd_shared & st_q.cfg[CTL_DATA];

        st_d.flag1 = h1_hit | (st_q.flag1 & ~rd_clear);
        st_d.flag2 = h2_hit | (st_q.flag2 & ~rd_clear);

        if (wr_shared) begin
            if (st_q.cfg[CTL_DATA]) st_d.lat = wdata;
            else                    st_d.dir = wdata;
        end
        if (wr_ctl) st_d.cfg = wdata[CFG_W-1:0];

        st_d.h1_prev = h1_s;
        st_d.h2_prev = h2_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out      = st_q.lat;
    assign pin_oe       = st_q.dir;
    assign hs2_oe       = st_q.cfg[CTL_H2_OUT];
    assign hs2_out      = st_q.cfg[CTL_H2_OUT] & st_q.cfg[CTL_H2_LVL];
    assign irq_n        = ~(st_q.cfg[CTL_IRQ_EN] & (st_q.flag1 | st_q.flag2));
    assign shared_rdata = st_q.cfg[CTL_DATA] ? ((st_q.lat & st_q.dir) | (pin_s & ~st_q.dir))
                                             : st_q.dir;
    assign ctl_rdata    = {st_q.flag1, st_q.flag2, st_q.cfg};

    // R10: a clearing read with no new edge leaves both flags low
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_shared && st_q.cfg[CTL_DATA] && !h1_hit && !h2_hit) |=> (!st_q.flag1 && !st_q.flag2));

    // R10: an edge coinciding with the clearing read wins
    a_r10_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_shared && h1_hit) |=> st_q.flag1);

    // R8: flag 2 never rises while line 2 is an output
    a_r8_no_flag2_as_output: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag2) |-> !$past(st_q.cfg[CTL_H2_OUT]));

    // R9: control writes do not disturb a set flag
    a_r9_flag_survives_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && st_q.flag1 && !rd_shared) |=> st_q.flag1);

    // R3: a direction write leaves the latch untouched
    a_r3_dir_write_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_shared && !st_q.cfg[CTL_DATA]) |=> $stable(st_q.lat));

endmodule

// File: rtl/dual_port_adapter.sv
module dual_port_adapter
    import pxa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_hi_a,
    input  logic             cs_hi_b,
    input  logic             cs_lo_n,
    input  logic [1:0]       reg_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [BUS_W-1:0] a_pin_in,
    output logic [BUS_W-1:0] a_pin_out,
    output logic [BUS_W-1:0] a_pin_oe,
    input  logic             a_hs1,
    input  logic             a_hs2_in,
    output logic             a_hs2_out,
    output logic             a_hs2_oe,
    output logic             a_irq_n,
    input  logic [BUS_W-1:0] b_pin_in,
    output logic [BUS_W-1:0] b_pin_out,
    output logic [BUS_W-1:0] b_pin_oe,
    input  logic             b_hs1,
    input  logic             b_hs2_in,
    output logic             b_hs2_out,
    output logic             b_hs2_oe,
    output logic             b_irq_n
);
    localparam int NPORT = 2;

    logic                             selected;
    logic [NPORT-1:0][BUS_W-1:0]      pin_in_v, pin_out_v, pin_oe_v, sh_rd_v, ctl_rd_v;
    logic [NPORT-1:0]                 hs1_v, hs2_in_v, hs2_out_v, hs2_oe_v, irq_v;
    logic [NPORT-1:0]                 wr_sh_v, wr_ctl_v, rd_sh_v;
    logic [BUS_W-1:0]                 rd_d, rd_q;

    assign selected = cs_hi_a & cs_hi_b & ~cs_lo_n;

    assign pin_in_v = {b_pin_in, a_pin_in};
    assign hs1_v    = {b_hs1, a_hs1};
    assign hs2_in_v = {b_hs2_in, a_hs2_in};

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            localparam logic [1:0] SH_ADDR  = 2'(2 * p);
            localparam logic [1:0] CTL_ADDR = 2'(2 * p + 1);

            assign wr_sh_v[p]  = selected & bus_wr & (reg_sel == SH_ADDR);
            assign wr_ctl_v[p] = selected & bus_wr & (reg_sel == CTL_ADDR);
            assign rd_sh_v[p]  = selected & bus_rd & (reg_sel == SH_ADDR);

            pxa_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
                .clk          (clk),
                .rst_n        (rst_n),
                .wr_shared    (wr_sh_v[p]),
                .wr_ctl       (wr_ctl_v[p]),
                .rd_shared    (rd_sh_v[p]),
                .wdata        (bus_wdata),
                .pin_in       (pin_in_v[p]),
                .hs1_in       (hs1_v[p]),
                .hs2_in       (hs2_in_v[p]),
                .pin_out      (pin_out_v[p]),
                .pin_oe       (pin_oe_v[p]),
                .hs2_out      (hs2_out_v[p]),
                .hs2_oe       (hs2_oe_v[p]),
                .irq_n        (irq_v[p]),
                .shared_rdata (sh_rd_v[p]),
                .ctl_rdata    (ctl_rd_v[p])
            );
        end
    endgenerate

    always_comb begin
        rd_d = rd_q;
        if (selected && bus_rd) begin
            case (reg_sel_e'(reg_sel))
                SEL_A_SHARED: rd_d = sh_rd_v[0];
                SEL_A_CTL:    rd_d = ctl_rd_v[0];
                SEL_B_SHARED: rd_d = sh_rd_v[1];
                default:      rd_d = ctl_rd_v[1];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;
    assign a_pin_out = pin_out_v[0];
    assign a_pin_oe  = pin_oe_v[0];
    assign a_hs2_out = hs2_out_v[0];
    assign a_hs2_oe  = hs2_oe_v[0];
    assign a_irq_n   = irq_v[0];
    assign b_pin_out = pin_out_v[1];
    assign b_pin_oe  = pin_oe_v[1];
    assign b_hs2_out = hs2_out_v[1];
    assign b_hs2_oe  = hs2_oe_v[1];
    assign b_irq_n   = irq_v[1];

    // R1: without a selected read the read register holds
    a_r1_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(selected && bus_rd) |=> $stable(bus_rdata));

    // R1: a deselected cycle changes no pin configuration
    a_r1_deselect_no_config: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |=> ($stable(a_pin_oe) && $stable(b_pin_oe) && $stable(a_pin_out) && $stable(b_pin_out)));

endmodule

// File: tb/dual_port_adapter_tb_top.sv
module dual_port_adapter_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_hi_a = 1'b1, cs_hi_b = 1'b1, cs_lo_n = 1'b0;
    logic [1:0] reg_sel = 2'b00;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] a_pin_in = 8'h00, b_pin_in = 8'h00;
    logic [7:0] a_pin_out, a_pin_oe, b_pin_out, b_pin_oe;
    logic a_hs1 = 1'b0, a_hs2_in = 1'b0, b_hs1 = 1'b0, b_hs2_in = 1'b0;
    logic a_hs2_out, a_hs2_oe, a_irq_n, b_hs2_out, b_hs2_oe, b_irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dual_port_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .cs_hi_a(cs_hi_a), .cs_hi_b(cs_hi_b), .cs_lo_n(cs_lo_n),
        .reg_sel(reg_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
        .a_hs1(a_hs1), .a_hs2_in(a_hs2_in), .a_hs2_out(a_hs2_out), .a_hs2_oe(a_hs2_oe),
        .a_irq_n(a_irq_n),
        .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
        .b_hs1(b_hs1), .b_hs2_in(b_hs2_in), .b_hs2_out(b_hs2_out), .b_hs2_oe(b_hs2_oe),
        .b_irq_n(b_irq_n)
    );

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_dir[2], m_lat[2], m_cfg[2], m_f1[2], m_f2[2];
    int m_pin_hist[2][2];      // [0] newest sample, [1] visible level
    int m_h1_hist[2][3];       // [1] visible level, [2] one cycle older
    int m_h2_hist[2][3];
    int m_rd;

    always @(posedge clk) begin
        int sel, pins[2], h1[2], h2[2];
        int shv, e1, e2, clr;
        pins[0] = a_pin_in; pins[1] = b_pin_in;
        h1[0] = a_hs1;  h1[1] = b_hs1;
        h2[0] = a_hs2_in; h2[1] = b_hs2_in;
        if (!rst_n) begin
            m_rd = 0;
            for (int p = 0; p < 2; p++) begin
                m_dir[p] = 0; m_lat[p] = 0; m_cfg[p] = 0; m_f1[p] = 0; m_f2[p] = 0;
                for (int k = 0; k < 2; k++) m_pin_hist[p][k] = 0;
                for (int k = 0; k < 3; k++) begin m_h1_hist[p][k] = 0; m_h2_hist[p][k] = 0; end
            end
        end else begin
            sel = (cs_hi_a && cs_hi_b && !cs_lo_n) ? 1 : 0;
            if (sel != 0 && bus_rd) begin
                int p;
                p = reg_sel[1];
                if (reg_sel[0]) m_rd = m_f1[p] * 128 + m_f2[p] * 64 + m_cfg[p];
                else if (m_cfg[p][2]) m_rd = (m_lat[p] & m_dir[p]) | (m_pin_hist[p][1] & ~m_dir[p] & 255);
                else m_rd = m_dir[p];
            end
            for (int p = 0; p < 2; p++) begin
                int c;
                c = m_cfg[p];
                shv = (reg_sel == 2'(2 * p)) ? 1 : 0;
                e1 = c[1] ? (m_h1_hist[p][1] == 1 && m_h1_hist[p][2] == 0)
                          : (m_h1_hist[p][1] == 0 && m_h1_hist[p][2] == 1);
                e2 = (!c[5] && c[3]) &&
                     (c[4] ? (m_h2_hist[p][1] == 1 && m_h2_hist[p][2] == 0)
                           : (m_h2_hist[p][1] == 0 && m_h2_hist[p][2] == 1));
                clr = (sel != 0 && bus_rd && shv != 0 && c[2]) ? 1 : 0;
                if (e1 != 0) m_f1[p] = 1; else if (clr != 0) m_f1[p] = 0;
                if (e2 != 0) m_f2[p] = 1; else if (clr != 0) m_f2[p] = 0;
                if (sel != 0 && bus_wr && shv != 0) begin
                    if (c[2]) m_lat[p] = bus_wdata; else m_dir[p] = bus_wdata;
                end
                if (sel != 0 && bus_wr && reg_sel == 2'(2 * p + 1)) m_cfg[p] = bus_wdata & 8'h3F;
                m_pin_hist[p][1] = m_pin_hist[p][0]; m_pin_hist[p][0] = pins[p];
                m_h1_hist[p][2] = m_h1_hist[p][1]; m_h1_hist[p][1] = m_h1_hist[p][0]; m_h1_hist[p][0] = h1[p];
                m_h2_hist[p][2] = m_h2_hist[p][1]; m_h2_hist[p][1] = m_h2_hist[p][0]; m_h2_hist[p][0] = h2[p];
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            chk("R5 model rdata", bus_rdata, 8'(m_rd));
            chk("R4 model a_pin_oe", a_pin_oe, 8'(m_dir[0]));
            chk("R4 model b_pin_oe", b_pin_oe, 8'(m_dir[1]));
            chk("R3 model a_pin_out", a_pin_out, 8'(m_lat[0]));
            chk("R3 model b_pin_out", b_pin_out, 8'(m_lat[1]));
            chk("R11 model irq", {6'd0, b_irq_n, a_irq_n},
                {6'd0, !(m_cfg[1][0] && (m_f1[1] || m_f2[1])), !(m_cfg[0][0] && (m_f1[0] || m_f2[0]))});
            chk("R8 model hs2", {4'd0, b_hs2_oe, b_hs2_out, a_hs2_oe, a_hs2_out},
                {4'd0, m_cfg[1][5], m_cfg[1][5] && m_cfg[1][3], m_cfg[0][5], m_cfg[0][5] && m_cfg[0][3]});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] v);
        @(negedge clk);
        reg_sel = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_sel = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // R6 reset state
        chk("R6 rdata", bus_rdata, 8'h00);
        chk("R6 a_pin_oe", a_pin_oe, 8'h00);
        chk("R6 b_pin_oe", b_pin_oe, 8'h00);
        chk("R6 irq_n", {6'd0, b_irq_n, a_irq_n}, 8'h03);
        chk("R6 hs2_oe", {6'd0, b_hs2_oe, a_hs2_oe}, 8'h00);

        // R3/R4 direction first (bit 2 clear after reset)
        wr(2'b00, 8'h4C);
        chk("R4 a_pin_oe 0x4C", a_pin_oe, 8'h4C);
        rd(2'b00, v);
        chk("R3 dir readback", v, 8'h4C);
        wr(2'b01, 8'h04);
        wr(2'b00, 8'hFF);
        chk("R3 latch written", a_pin_out, 8'hFF);
        chk("R3 dir untouched", a_pin_oe, 8'h4C);

        // R5 mixed read
        @(negedge clk); a_pin_in = 8'hA5;
        idle(3);
        rd(2'b00, v);
        chk("R5 mixed read", v, 8'hED);

        // R2 / R12 port B addressing
        wr(2'b10, 8'h0F);
        chk("R2 b dir", b_pin_oe, 8'h0F);
        chk("R12 a dir unaffected", a_pin_oe, 8'h4C);
        rd(2'b01, v);
        chk("R2 ctl A read", v, 8'h04);

        // R1 each select line deasserted in turn
        for (int k = 0; k < 3; k++) begin
            cs_hi_a = (k != 0); cs_hi_b = (k != 1); cs_lo_n = (k == 2);
            wr(2'b00, 8'h00);
            chk("R1 write ignored", a_pin_out, 8'hFF);
            rd(2'b10, v);
            chk("R1 rdata held", v, 8'h04);
        end
        cs_hi_a = 1'b1; cs_hi_b = 1'b1; cs_lo_n = 1'b0;

        // R7 falling edge on line 1, R11 irq
        wr(2'b01, 8'h05);
        @(negedge clk); a_hs1 = 1'b1;
        idle(5);
        chk("R7 rising ignored", {7'd0, a_irq_n}, 8'h01);
        @(negedge clk); a_hs1 = 1'b0;
        idle(3);
        chk("R11 irq asserted", {7'd0, a_irq_n}, 8'h00);
        rd(2'b01, v);
        chk("R7 flag bit7", v, 8'h85);

        // R9 read-only flags
        wr(2'b01, 8'hC5);
        rd(2'b01, v);
        chk("R9 flags read-only", v, 8'h85);

        // R10 data read clears
        rd(2'b00, v);
        rd(2'b01, v);
        chk("R10 cleared", v, 8'h05);
        chk("R10 irq released", {7'd0, a_irq_n}, 8'h01);

        // R11 masked
        wr(2'b01, 8'h04);
        @(negedge clk); a_hs1 = 1'b1;
        idle(4);
        @(negedge clk); a_hs1 = 1'b0;
        idle(4);
        chk("R11 masked irq", {7'd0, a_irq_n}, 8'h01);
        rd(2'b01, v);
        chk("R11 flag set though masked", v, 8'h84);
        rd(2'b00, v);

        // R8 line 2 input, rising, armed
        wr(2'b01, 8'h1D);
        @(negedge clk); a_hs2_in = 1'b1;
        idle(4);
        chk("R8 irq from line2", {7'd0, a_irq_n}, 8'h00);
        rd(2'b01, v);
        chk("R8 flag bit6", v, 8'h5D);
        rd(2'b00, v);
        wr(2'b01, 8'h15);
        @(negedge clk); a_hs2_in = 1'b0;
        idle(4);
        @(negedge clk); a_hs2_in = 1'b1;
        idle(4);
        rd(2'b01, v);
        chk("R8 disarmed no flag", v, 8'h15);

        // R8 line 2 output
        wr(2'b01, 8'h3C);
        chk("R8 out high", {6'd0, a_hs2_oe, a_hs2_out}, 8'h03);
        wr(2'b01, 8'h34);
        chk("R8 out low", {6'd0, a_hs2_oe, a_hs2_out}, 8'h02);
        @(negedge clk); a_hs2_in = 1'b0;
        idle(4);
        @(negedge clk); a_hs2_in = 1'b1;
        idle(4);
        rd(2'b01, v);
        chk("R8 no flag as output", v, 8'h34);

        // R5 port B read
        wr(2'b11, 8'h04);
        wr(2'b10, 8'h3C);
        @(negedge clk); b_pin_in = 8'hF0;
        idle(3);
        rd(2'b10, v);
        chk("R5 port B read", v, 8'hFC);

        // R7 rising select on port B, R12 independence
        wr(2'b11, 8'h07);
        @(negedge clk); b_hs1 = 1'b1;
        idle(4);
        chk("R12 irq B only", {6'd0, b_irq_n, a_irq_n}, 8'h01);
        rd(2'b11, v);
        chk("R7 rising flag B", v, 8'h87);

        // R10 edge in the same cycle as the clearing read
        rd(2'b10, v);
        @(negedge clk); b_hs1 = 1'b0;
        idle(4);
        chk("R7 falling ignored on B", {7'd0, b_irq_n}, 8'h01);
        @(negedge clk); b_hs1 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_sel = 2'b10; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R10 edge beats clear irq", {7'd0, b_irq_n}, 8'h00);
        rd(2'b11, v);
        chk("R10 edge beats clear flag", v, 8'h87);

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule